// File: doc/BRIEF.md
# Multi-Drop Addressable Serial Control Port

This block is the control-port slave of a configurable device. A host reaches it over three wires: an active-low frame enable, a serial clock and a serial data line. It reads and writes a small file of 16-bit configuration registers. Up to four such devices can hang on the same three wires with no separate select line for each one. Every device carries two strap pins that give it an identity.

Addressing works in two stages.
- After a hardware reset, the address field of each frame is ignored and every device on the bus takes every write. The host can therefore load common settings into all devices at once.
- Once the address-enable bit of control register 0 has been written to one, a device acts only on frames whose 2-bit device field equals its straps.

Control register 0 also holds three further settings:
- a 4-wire bit, which moves read data off the shared data line onto a separate output;
- a software-control bit, which lets register bits take over the enable, mode and run/reset signals that normally come from pins;
- the register bits that supply those three signals while software control is on.

All serial pins are brought into the system clock through two-flop synchronisers and are oversampled there. A write takes effect only when the enable line returns high at the end of a complete frame.

Top module: `mdrop_ctl_port`

## Requirements
- R1: A frame is 26 bits sent MSB first, one bit per rising serial clock while the enable is low. The bits are, in order: read flag (1 = read), 2-bit device field, 7-bit register index, 16-bit data word.
- R2: After reset, the address-enable bit (bit 0 of register 0) is 0, and a write is accepted whatever its device field.
- R3: With the address-enable bit at 1, a frame is accepted only when its device field equals the strap pins. The frame that writes the address-enable bit is judged by the value the bit had before that frame.
- R4: A frame with other than exactly 26 clock edges before the enable rises changes no register.
- R5: With the 4-wire bit (bit 1 of register 0) at 1, read data appears on `dout` with `dout_oe` high, and `sdio_oe` stays low. At no time are both output enables high.
- R6: When the software-control bit (bit 2 of register 0) is 0, `core_enable` follows `pin_enable`, `core_mode` follows `pin_mode`, and `core_reset_n` is 1. When that bit is 1, these three outputs come from register 0 bits 3, 4 and 5 respectively, and the pins have no effect.
- R7: A low on `rst_n` returns every register, including the address-enable bit, to zero. It also drops both output enables and `core_reset_n`.
- R8: In 3-wire mode an accepted read drives `sdio_out` with `sdio_oe` high after the tenth clock edge. The data bits come MSB first: the value presented before edge 11 is bit 15, and each later edge moves on one bit. Both output enables are released once the frame enable goes high, and a non-matching read never drives.
- R9: Writes to a register index of 8 or above change nothing, and reads of such an index return zero.
- R10: A complete write frame changes its register only after the enable rises, not when the last data bit is clocked in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ser_en_n | input | 1 | Frame enable, active low |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data in |
| strap_addr | input | 2 | Device identity straps |
| pin_enable | input | 1 | Enable from pin |
| pin_mode | input | 1 | Mode from pin |
| sdio_out | output | 1 | Read data for the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| dout | output | 1 | Read data for the separate output pin |
| dout_oe | output | 1 | Drive enable for the separate output pin |
| core_enable | output | 1 | Selected enable to the device core |
| core_mode | output | 1 | Selected mode to the device core |
| core_reset_n | output | 1 | Selected run/reset to the device core, active low |
| cfg_regs | output | 128 | All registers, register i at bits 16*i+15 : 16*i |

## Verification
Two events meet in the same cycle when a frame writes the address-enable bit. That frame's commit updates the bit, and the acceptance test for the same frame reads it. The bench provokes this by setting the bit with a device field that does not match the straps. The frame must still land, as judged from `cfg_regs`, and the next mismatched write must be refused. A second coincidence is the release of the output enable and the commit pulse, which both follow the same synchronised rise of the frame enable. The bench checks both enables just after each read frame and scores every read value against a queue of expected words.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

    // positions inside control register 0
    localparam int CTRL_IDX      = 0;
    localparam int CTRL_FLAGS_W  = 6;

    typedef struct packed {
        logic sw_run;     // bit 5
        logic sw_mode;    // bit 4
        logic sw_enable;  // bit 3
        logic sw_ctl;     // bit 2
        logic four_wire;  // bit 1
        logic addr_en;    // bit 0
    } ctrl_t;

    // order of the synchronised pin bundle
    localparam int SY_EN_N = 4;
    localparam int SY_SCLK = 3;
    localparam int SY_DIN  = 2;
    localparam int SY_PEN  = 1;
    localparam int SY_PMOD = 0;
    localparam int SY_W    = 5;

endpackage

// File: rtl/mdc_sync.sv
module mdc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign q_o = st_q.stg[STAGES-1];
endmodule

// File: rtl/mdc_frame_rx.sv
module mdc_frame_rx #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 7,
    parameter int DEV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sen_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              rise_o,
    output logic              hdr_o,
    output logic              hdr_rw_o,
    output logic [DEV_W-1:0]  hdr_dev_o,
    output logic [IDX_W-1:0]  hdr_idx_o,
    output logic              done_o,
    output logic              frm_rw_o,
    output logic [DEV_W-1:0]  frm_dev_o,
    output logic [IDX_W-1:0]  frm_idx_o,
    output logic [DATA_W-1:0] frm_data_o
);
    localparam int HDR_BITS   = 1 + DEV_W + IDX_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic                  sclk_prev;
        logic                  sen_prev;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] sh;
        logic                  rise;
        logic                  hdr;
        logic                  done;
    } rx_s;

    rx_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.rise      = 1'b0;
        st_d.hdr       = 1'b0;
        st_d.done      = 1'b0;
        st_d.sclk_prev = sclk_i;
        st_d.sen_prev  = sen_i;
        if (!sen_i && st_q.sen_prev) begin
            st_d.cnt = '0;                       // start of frame
        end else if (!sen_i && sclk_i && !st_q.sclk_prev) begin
            st_d.rise = 1'b1;
            st_d.sh   = {st_q.sh[FRAME_BITS-2:0], sdi_i};
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_HDR) st_d.hdr = 1'b1;
        end
        if (sen_i && !st_q.sen_prev && st_q.cnt == CNT_FULL) begin
            st_d.done = 1'b1;                    // complete frame closed
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.sen_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o     = st_q.rise;
    assign hdr_o      = st_q.hdr;
    assign hdr_rw_o   = st_q.sh[HDR_BITS-1];
    assign hdr_dev_o  = st_q.sh[HDR_BITS-2 -: DEV_W];
    assign hdr_idx_o  = st_q.sh[IDX_W-1:0];
    assign done_o     = st_q.done;
    assign frm_rw_o   = st_q.sh[FRAME_BITS-1];
    assign frm_dev_o  = st_q.sh[FRAME_BITS-2 -: DEV_W];
    assign frm_idx_o  = st_q.sh[DATA_W +: IDX_W];
    assign frm_data_o = st_q.sh[DATA_W-1:0];

    AST_HDR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hdr |-> !$past(sen_i)) else $error("header outside frame"); // R1
endmodule

// File: rtl/mdc_regfile.sv
module mdc_regfile
    import mdc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    parameter int IDX_W  = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [IDX_W-1:0]       wr_idx_i,
    input  logic [DATA_W-1:0]      wr_data_i,
    input  logic [IDX_W-1:0]       rd_idx_i,
    output logic [DATA_W-1:0]      rd_data_o,
    output ctrl_t                  ctrl_o,
    output logic [NREG*DATA_W-1:0] regs_o
);
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NREG);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] r;
    } rf_s;

    rf_s  st_d, st_q;
    logic wr_ok, rd_ok;

    assign wr_ok = {1'b0, wr_idx_i} < LIMIT;
    assign rd_ok = {1'b0, rd_idx_i} < LIMIT;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && wr_ok) st_d.r[wr_idx_i[SEL_W-1:0]] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = rd_ok ? st_q.r[rd_idx_i[SEL_W-1:0]] : '0;
    assign ctrl_o    = ctrl_t'(st_q.r[CTRL_IDX][CTRL_FLAGS_W-1:0]);

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_o[g*DATA_W +: DATA_W] = st_q.r[g];
    end

    AST_ADDR_EN_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.r[CTRL_IDX][0]) |-> $past(wr_en_i && wr_idx_i == IDX_W'(CTRL_IDX)))
        else $error("address enable set without write"); // R3
    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_ok) |=> $stable(st_q.r))
        else $error("out of range write changed state"); // R9
endmodule

// File: rtl/mdrop_ctl_port.sv
module mdrop_ctl_port
    import mdc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    parameter int IDX_W  = 7,
    parameter int DEV_W  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_en_n,
    input  logic                   ser_clk,
    input  logic                   ser_din,
    input  logic [DEV_W-1:0]       strap_addr,
    input  logic                   pin_enable,
    input  logic                   pin_mode,
    output logic                   sdio_out,
    output logic                   sdio_oe,
    output logic                   dout,
    output logic                   dout_oe,
    output logic                   core_enable,
    output logic                   core_mode,
    output logic                   core_reset_n,
    output logic [NREG*DATA_W-1:0] cfg_regs
);
    localparam logic [SY_W-1:0] SY_RST = SY_W'(1) << SY_EN_N;

    logic [SY_W-1:0] pins_s;
    logic sen_s;

    mdc_sync #(.W(SY_W), .STAGES(SYNC_STAGES), .RST_VAL(SY_RST)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({ser_en_n, ser_clk, ser_din, pin_enable, pin_mode}),
        .q_o(pins_s)
    );
    assign sen_s = pins_s[SY_EN_N];

    logic              rise, hdr, hdr_rw, done, frm_rw;
    logic [DEV_W-1:0]  hdr_dev, frm_dev;
    logic [IDX_W-1:0]  hdr_idx, frm_idx;
    logic [DATA_W-1:0] frm_data, rd_data;
    ctrl_t             ctrl;
    logic              accept_hdr, accept_frm, wr_en;

    mdc_frame_rx #(.DATA_W(DATA_W), .IDX_W(IDX_W), .DEV_W(DEV_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .sen_i(sen_s), .sclk_i(pins_s[SY_SCLK]), .sdi_i(pins_s[SY_DIN]),
        .rise_o(rise), .hdr_o(hdr), .hdr_rw_o(hdr_rw), .hdr_dev_o(hdr_dev),
        .hdr_idx_o(hdr_idx), .done_o(done), .frm_rw_o(frm_rw),
        .frm_dev_o(frm_dev), .frm_idx_o(frm_idx), .frm_data_o(frm_data)
    );

    // broadcast until the address-enable bit is set, then strap match
    assign accept_hdr = !ctrl.addr_en || (hdr_dev == strap_addr);
    assign accept_frm = !ctrl.addr_en || (frm_dev == strap_addr);
    assign wr_en      = done && !frm_rw && accept_frm;

    mdc_regfile #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_idx_i(frm_idx), .wr_data_i(frm_data),
        .rd_idx_i(hdr_idx), .rd_data_o(rd_data),
        .ctrl_o(ctrl), .regs_o(cfg_regs)
    );

    typedef struct packed {
        logic              drv;
        logic [DATA_W-1:0] osh;
        logic              c_en;
        logic              c_mode;
        logic              c_rst_n;
    } top_s;

    top_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sen_s) begin
            st_d.drv = 1'b0;
        end else if (hdr && hdr_rw && accept_hdr) begin
            st_d.drv = 1'b1;
            st_d.osh = rd_data;
        end else if (rise && st_q.drv) begin
            st_d.osh = {st_q.osh[DATA_W-2:0], 1'b0};
        end
        st_d.c_en    = ctrl.sw_ctl ? ctrl.sw_enable : pins_s[SY_PEN];
        st_d.c_mode  = ctrl.sw_ctl ? ctrl.sw_mode   : pins_s[SY_PMOD];
        st_d.c_rst_n = ctrl.sw_ctl ? ctrl.sw_run    : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdio_out     = st_q.osh[DATA_W-1];
    assign dout         = st_q.osh[DATA_W-1];
    assign sdio_oe      = st_q.drv && !ctrl.four_wire;
    assign dout_oe      = st_q.drv &&  ctrl.four_wire;
    assign core_enable  = st_q.c_en;
    assign core_mode    = st_q.c_mode;
    assign core_reset_n = st_q.c_rst_n;

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        sen_s |=> !(sdio_oe || dout_oe)) else $error("drive held after frame"); // R8
    AST_DRIVE_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.drv) |-> $past(hdr)) else $error("drive without header"); // R8
    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe && dout_oe)) else $error("both lines driven"); // R5
endmodule

// File: tb/mdrop_ctl_port_bench.sv
module mdrop_ctl_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sen_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [1:0] strap = 2'd2;
    logic pen = 1'b0, pmode = 1'b0;
    logic sdio_out, sdio_oe, dout, dout_oe, c_en, c_mode, c_rst_n;
    logic [127:0] cfg;

    always #2.5 clk = ~clk;

    mdrop_ctl_port u_mdrop_ctl_port (
        .clk(clk), .rst_n(rst_n), .ser_en_n(sen_n), .ser_clk(sclk), .ser_din(sdi),
        .strap_addr(strap), .pin_enable(pen), .pin_mode(pmode),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .dout(dout), .dout_oe(dout_oe),
        .core_enable(c_en), .core_mode(c_mode), .core_reset_n(c_rst_n), .cfg_regs(cfg)
    );

    localparam int HALF = 10;
    int checks = 0, failures = 0;
    bit fin = 0;
    logic [15:0] exp_q[$], act_q[$];
    string tag_q[$];
    bit seen_sdio, seen_dout;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // one frame: nbits edges, read data collected before edges 11..26
    task automatic xfer(input bit rw, input logic [1:0] dev, input logic [6:0] idx,
                        input logic [15:0] data, input int nbits, input bit fw,
                        input bit hold, output logic [15:0] got);
        logic [25:0] f;
        f = {rw, dev, idx, data};
        got = '0; seen_sdio = 0; seen_dout = 0;
        sen_n = 1'b0;
        clks(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 26 && !(rw && i >= 10)) ? f[25-i] : 1'b0;
            clks(HALF);
            if (rw && i >= 10 && i < 26) begin
                got[25-i] = fw ? dout : sdio_out;
                seen_sdio |= sdio_oe;
                seen_dout |= dout_oe;
            end
            sclk = 1'b1;
            clks(HALF);
            sclk = 1'b0;
        end
        clks(HALF);
        if (!hold) begin
            sen_n = 1'b1;
            clks(4*HALF);
        end
    endtask

    task automatic wr(input logic [1:0] dev, input logic [6:0] idx, input logic [15:0] d);
        logic [15:0] g;
        xfer(1'b0, dev, idx, d, 26, 1'b0, 1'b0, g);
    endtask

    task automatic rd(input logic [1:0] dev, input logic [6:0] idx, input bit fw,
                      input logic [15:0] exp, input string tag);
        logic [15:0] g;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        xfer(1'b1, dev, idx, 16'h0, 26, fw, 1'b0, g);
        act_q.push_back(g);
        clks(2);
    endtask

    function automatic logic [15:0] reg_of(input int i);
        return cfg[i*16 +: 16];
    endfunction

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [15:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(a == e, t, {16'h0, a}, {16'h0, e});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            checks++; failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] g;
        clks(5);
        rst_n = 1'b1;
        clks(6);
        // R7 reset state
        chk(cfg == '0, "R7 registers zero after reset", cfg[31:0], 32'h0);
        chk(!sdio_oe && !dout_oe, "R7 no drive after reset", {sdio_oe, dout_oe}, 0);
        chk(c_rst_n == 1'b1 && c_en == 1'b0, "R6 pin path after reset", {c_rst_n, c_en}, 32'h2);

        // R2 broadcast: device field 1 with straps 2
        wr(2'd1, 7'd1, 16'hA55A);
        chk(reg_of(1) == 16'hA55A, "R2 broadcast write accepted", reg_of(1), 16'hA55A);
        rd(2'd3, 7'd1, 1'b0, 16'hA55A, "R1 R8 broadcast read MSB first");
        chk(seen_sdio && !seen_dout, "R8 3-wire read drives shared line", {seen_sdio, seen_dout}, 32'h2);
        chk(!sdio_oe && !dout_oe, "R8 drive released after enable high", {sdio_oe, dout_oe}, 0);
        rd(2'd0, 7'd1, 1'b0, 16'hA55A, "R8 second read same word");

        // R10 commit only at enable rise
        xfer(1'b0, 2'd2, 7'd3, 16'h1357, 26, 1'b0, 1'b1, g);
        chk(reg_of(3) == 16'h0, "R10 no change before enable rise", reg_of(3), 0);
        sen_n = 1'b1;
        clks(4*HALF);
        chk(reg_of(3) == 16'h1357, "R10 change after enable rise", reg_of(3), 16'h1357);

        // R4 short and long frames discarded
        xfer(1'b0, 2'd2, 7'd4, 16'hFFFF, 20, 1'b0, 1'b0, g);
        chk(reg_of(4) == 16'h0, "R4 short frame discarded", reg_of(4), 0);
        xfer(1'b0, 2'd2, 7'd4, 16'hFFFF, 27, 1'b0, 1'b0, g);
        chk(reg_of(4) == 16'h0, "R4 long frame discarded", reg_of(4), 0);

        // R9 out of range index
        wr(2'd2, 7'd100, 16'hDEAD);
        chk(cfg[127:16] == {96'h0, 16'h1357, 16'h0, 16'hA55A}, "R9 out of range write ignored",
            cfg[63:32], {16'h0, 16'h1357});
        rd(2'd2, 7'd100, 1'b0, 16'h0000, "R9 out of range read zero");

        // R3 set address enable with a mismatched device field
        wr(2'd0, 7'd0, 16'h0001);
        chk(reg_of(0) == 16'h0001, "R3 enabling frame judged as broadcast", reg_of(0), 1);
        wr(2'd1, 7'd5, 16'h1234);
        chk(reg_of(5) == 16'h0, "R3 mismatched write refused", reg_of(5), 0);
        xfer(1'b1, 2'd1, 7'd1, 16'h0, 26, 1'b0, 1'b0, g);
        chk(!seen_sdio && !seen_dout, "R8 mismatched read never drives", {seen_sdio, seen_dout}, 0);
        wr(2'd2, 7'd5, 16'h1234);
        chk(reg_of(5) == 16'h1234, "R3 matching write accepted", reg_of(5), 16'h1234);
        strap = 2'd1;
        clks(4);
        rd(2'd1, 7'd5, 1'b0, 16'h1234, "R3 read after strap change");

        // R5 four-wire
        wr(2'd1, 7'd0, 16'h0003);
        rd(2'd1, 7'd5, 1'b1, 16'h1234, "R5 read on separate pin");
        chk(seen_dout && !seen_sdio, "R5 shared line stays input", {seen_sdio, seen_dout}, 32'h1);
        chk(!sdio_oe && !dout_oe, "R8 separate pin released", {sdio_oe, dout_oe}, 0);

        // R6 pins then software control
        pen = 1'b1; pmode = 1'b1;
        clks(6);
        chk(c_en && c_mode && c_rst_n, "R6 pins drive core", {c_en, c_mode, c_rst_n}, 32'h7);
        wr(2'd1, 7'd0, 16'h002D);
        pen = 1'b0;
        clks(6);
        chk(c_en && !c_mode && c_rst_n, "R6 software values win over pins", {c_en, c_mode, c_rst_n}, 32'h5);
        wr(2'd1, 7'd0, 16'h0005);
        clks(4);
        chk(!c_en && !c_rst_n, "R6 software run low", {c_en, c_rst_n}, 0);

        // R7 hardware reset clears address enable
        rst_n = 1'b0;
        clks(3);
        rst_n = 1'b1;
        clks(6);
        chk(cfg == '0, "R7 registers cleared by reset", cfg[31:0], 0);
        wr(2'd3, 7'd2, 16'hBEEF);
        chk(reg_of(2) == 16'hBEEF, "R7 broadcast again after reset", reg_of(2), 16'hBEEF);

        clks(10);
        while (act_q.size() > 0) clks(1);
        fin = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule